// File: doc/BRIEF.md
# External Audio Clock Frequency Meter

This block measures how long one period of an external digital-audio word clock lasts, counted in ticks of a 28.224 MHz reference clock. One of two external clock inputs is chosen as the source. That input is brought into the reference domain through a two-flop synchroniser, and the block counts the reference cycles between successive rising edges.

Software first issues a start command that names the source. This restarts the measurement. Once the input has settled, software issues a save command, which freezes the latest period count into a 10-bit result split into a 2-bit high part and an 8-bit low part. The result is only meaningful when the chosen input reports both clock-present and data-present, so the saved value is forced to zero when either flag is low. The frequency equals 28 224 000 divided by the count. An optional stage turns the frozen count into the nearest standard sample rate. A sticky flag records when the input was slower than the counter can measure.

Top module: `audio_clk_meter`

## Requirements
- R1: After reset, `cnt_hi`, `cnt_lo`, `rate_hz` and `overflow` are all zero.
- R2: A command with `cmd_save`=0 and a non-zero `cmd_src` starts a measurement. `cmd_src[1]`=1 selects input B, and otherwise `cmd_src[0]`=1 selects input A. A start clears `overflow` in the next cycle.
- R3: A certain number of reference cycles after a start, a save returns the selected input's period in reference cycles. That number is at least three input periods.
- R4: A command with `cmd_save`=1 freezes the count in the next cycle. Count bits [9:8] appear on `cnt_hi` and bits [7:0] on `cnt_lo`. The frozen value holds until the next save. A save ignores `cmd_src` and neither restarts the measurement nor changes the source.
- R5: A save stores zero if the selected input's clock-present or data-present flag is low. The flags of the input that is not selected have no effect.
- R6: A period of 1023 or more cycles reads 1023. A period of 1024 or more cycles sets `overflow`, which then stays set until the next start, even after the input speeds up.
- R7: `rate_hz` maps the frozen count c to a rate through floor(28224000/c). A value above 184200 gives 192000, above 152200 gives 176400, above 112000 gives 128000, above 92100 gives 96000, above 76100 gives 88200, above 56000 gives 64000, above 46050 gives 48000, above 38050 gives 44100, above 28000 gives 32000, and above 23025 gives 24000. A count of 0 gives 0.
- R8: After a start that selects input B, measurements follow input B's period, and the period of input A has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 28.224 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_a | input | 1 | External word clock A (sync input), asynchronous |
| ext_clk_b | input | 1 | External word clock B (second digital input), asynchronous |
| clk_ok_a | input | 1 | Clock-present flag of input A |
| data_ok_a | input | 1 | Data-present flag of input A |
| clk_ok_b | input | 1 | Clock-present flag of input B |
| data_ok_b | input | 1 | Data-present flag of input B |
| cmd_we | input | 1 | Command strobe, one cycle |
| cmd_src | input | 2 | Source field: bit 0 input A, bit 1 input B |
| cmd_save | input | 1 | Save bit: freeze the count instead of starting |
| cnt_hi | output | 2 | Frozen count bits [9:8] |
| cnt_lo | output | 8 | Frozen count bits [7:0] |
| overflow | output | 1 | Sticky: input slower than the counter range |
| rate_hz | output | 18 | Rounded sample rate of the frozen count |

## Verification
The bench builds the block with its default parameters: a 10-bit count, a 28 224 000 Hz reference and the rounding stage enabled. With these values, periods near 147 cycles reach the 192 kHz bucket and periods above 1007 cycles fall into the 24 kHz bucket. The exact saturation edges at 1023 and 1024 cycles are also within reach, and a 1500-cycle input still runs quickly enough to drive the overflow case.

// File: rtl/audio_clk_meter.sv
`timescale 1ns/1ps
module audio_clk_meter #(
  parameter int CNT_W    = 10,
  parameter int REF_HZ   = 28224000,
  parameter int ROUND_EN = 1,
  parameter int RATE_W   = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk_a,
  input  logic              ext_clk_b,
  input  logic              clk_ok_a,
  input  logic              data_ok_a,
  input  logic              clk_ok_b,
  input  logic              data_ok_b,
  input  logic              cmd_we,
  input  logic [1:0]        cmd_src,
  input  logic              cmd_save,
  output logic [CNT_W-9:0]  cnt_hi,
  output logic [7:0]        cnt_lo,
  output logic              overflow,
  output logic [RATE_W-1:0] rate_hz
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]       sy_a, sy_b;
  logic             src_b, primed;
  logic [CNT_W-1:0] run, meas, held;

  wire start_cmd = cmd_we & ~cmd_save & (|cmd_src);
  wire save_cmd  = cmd_we & cmd_save;
  wire rise      = src_b ? (sy_b[1] & ~sy_b[2]) : (sy_a[1] & ~sy_a[2]);
  wire present   = src_b ? (clk_ok_b & data_ok_b) : (clk_ok_a & data_ok_a);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy_a <= '0;
      sy_b <= '0;
    end else begin
      sy_a <= {sy_a[1:0], ext_clk_a};
      sy_b <= {sy_b[1:0], ext_clk_b};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_b    <= 1'b0;
      primed   <= 1'b0;
      run      <= '0;
      meas     <= '0;
      overflow <= 1'b0;
    end else if (start_cmd) begin
      src_b    <= cmd_src[1];
      primed   <= 1'b0;
      run      <= '0;
      meas     <= '0;
      overflow <= 1'b0;
    end else if (rise) begin
      if (primed) meas <= run;
      primed <= 1'b1;
      run    <= CNT_W'(1);
    end else if (run == CNT_MAX) begin
      meas     <= CNT_MAX;
      overflow <= 1'b1;
    end else begin
      run <= run + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        held <= '0;
    else if (save_cmd) held <= present ? meas : '0;
  end

  assign cnt_hi = held[CNT_W-1:8];
  assign cnt_lo = held[7:0];

  function automatic logic [RATE_W-1:0] to_rate(input logic [CNT_W-1:0] c);
    int v;
    v = 32'(c);
    if (v == 0)                      return '0;
    else if (v <= REF_HZ / 184201)   return RATE_W'(192000);
    else if (v <= REF_HZ / 152201)   return RATE_W'(176400);
    else if (v <= REF_HZ / 112001)   return RATE_W'(128000);
    else if (v <= REF_HZ / 92101)    return RATE_W'(96000);
    else if (v <= REF_HZ / 76101)    return RATE_W'(88200);
    else if (v <= REF_HZ / 56001)    return RATE_W'(64000);
    else if (v <= REF_HZ / 46051)    return RATE_W'(48000);
    else if (v <= REF_HZ / 38051)    return RATE_W'(44100);
    else if (v <= REF_HZ / 28001)    return RATE_W'(32000);
    else if (v <= REF_HZ / 23026)    return RATE_W'(24000);
    else if (v <= REF_HZ / 19026)    return RATE_W'(22050);
    else if (v <= REF_HZ / 14001)    return RATE_W'(16000);
    else if (v <= REF_HZ / 11513)    return RATE_W'(12000);
    else if (v <= REF_HZ / 9513)     return RATE_W'(11025);
    else if (v <= REF_HZ / 7001)     return RATE_W'(8000);
    else                             return '0;
  endfunction

  generate
    if (ROUND_EN != 0) begin : g_round
      assign rate_hz = to_rate(held);
    end else begin : g_noround
      assign rate_hz = '0;
    end
  endgenerate
endmodule

// File: rtl/audio_clk_meter_chk.sv
`timescale 1ns/1ps
module audio_clk_meter_chk #(
  parameter int CNT_W  = 10,
  parameter int RATE_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_we,
  input logic [1:0]        cmd_src,
  input logic              cmd_save,
  input logic              src_b,
  input logic              clk_ok_a,
  input logic              data_ok_a,
  input logic              clk_ok_b,
  input logic              data_ok_b,
  input logic [CNT_W-9:0]  cnt_hi,
  input logic [7:0]        cnt_lo,
  input logic              overflow,
  input logic [RATE_W-1:0] rate_hz
);
  wire start_c = cmd_we && !cmd_save && (cmd_src != 2'b00);
  wire save_c  = cmd_we && cmd_save;
  wire sel_ok  = src_b ? (clk_ok_b && data_ok_b) : (clk_ok_a && data_ok_a);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !save_c |=> $stable({cnt_hi, cnt_lo}));

  // R5
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_c && !sel_ok) |=> ({cnt_hi, cnt_lo} == '0));

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !start_c) |=> overflow);

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> !overflow);

  // R7
  zero_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({cnt_hi, cnt_lo} == '0) |-> (rate_hz == '0));
endmodule

bind audio_clk_meter audio_clk_meter_chk #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_src(cmd_src), .cmd_save(cmd_save),
  .src_b(src_b), .clk_ok_a(clk_ok_a), .data_ok_a(data_ok_a), .clk_ok_b(clk_ok_b),
  .data_ok_b(data_ok_b), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .overflow(overflow),
  .rate_hz(rate_hz));

// File: tb/tb_audio_clk_meter.sv
`timescale 1ns/1ps
module tb_audio_clk_meter;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ext_clk_a = 0, ext_clk_b = 0;
  logic clk_ok_a = 1, data_ok_a = 1, clk_ok_b = 1, data_ok_b = 1;
  logic cmd_we = 0, cmd_save = 0;
  logic [1:0] cmd_src = 0;
  logic [1:0] cnt_hi;
  logic [7:0] cnt_lo;
  logic overflow;
  logic [17:0] rate_hz;

  int hi_a = 50, lo_a = 50, hi_b = 40, lo_b = 40;
  int checks = 0, errors = 0;
  bit done = 0;

  audio_clk_meter dut (
    .clk(clk), .rst_n(rst_n), .ext_clk_a(ext_clk_a), .ext_clk_b(ext_clk_b),
    .clk_ok_a(clk_ok_a), .data_ok_a(data_ok_a), .clk_ok_b(clk_ok_b), .data_ok_b(data_ok_b),
    .cmd_we(cmd_we), .cmd_src(cmd_src), .cmd_save(cmd_save),
    .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .overflow(overflow), .rate_hz(rate_hz));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    repeat (hi_a) @(negedge clk); ext_clk_a = 1;
    repeat (lo_a) @(negedge clk); ext_clk_a = 0;
  end
  initial forever begin
    repeat (hi_b) @(negedge clk); ext_clk_b = 1;
    repeat (lo_b) @(negedge clk); ext_clk_b = 0;
  end

  function automatic int exp_cnt(int p, bit ok);
    if (!ok) return 0;
    return (p > 1023) ? 1023 : p;
  endfunction

  function automatic int exp_rate(int c);
    int f;
    f = (c == 0) ? 0 : 28224000 / c;
    if (f > 184200) return 192000;
    if (f > 152200) return 176400;
    if (f > 112000) return 128000;
    if (f > 92100)  return 96000;
    if (f > 76100)  return 88200;
    if (f > 56000)  return 64000;
    if (f > 46050)  return 48000;
    if (f > 38050)  return 44100;
    if (f > 28000)  return 32000;
    if (f > 23025)  return 24000;
    if (f > 19025)  return 22050;
    if (f > 14000)  return 16000;
    if (f > 11512)  return 12000;
    if (f > 9512)   return 11025;
    if (f > 7000)   return 8000;
    return 0;
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cmd(bit save, logic [1:0] src);
    @(negedge clk);
    cmd_we = 1; cmd_save = save; cmd_src = src;
    @(negedge clk);
    cmd_we = 0; cmd_save = 0; cmd_src = 0;
  endtask

  function automatic int cnt_now();
    return {cnt_hi, cnt_lo};
  endfunction

  task automatic measure(string req, bit use_b, int hi, int lo, bit ok);
    int p;
    p = hi + lo;
    if (use_b) begin hi_b = hi; lo_b = lo; end
    else begin hi_a = hi; lo_a = lo; end
    cmd(0, use_b ? 2'b10 : 2'b01);
    repeat (3 * p + 40) @(negedge clk);
    cmd(1, 2'b00);
    chk(req, cnt_now(), exp_cnt(p, ok));
    chk({req, " rate R7"}, int'(rate_hz), exp_rate(exp_cnt(p, ok)));
    chk({req, " ovf R6"}, int'(overflow), (p >= 1024) ? 1 : 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 count", cnt_now(), 0);
    chk("R1 rate", int'(rate_hz), 0);
    chk("R1 ovf", int'(overflow), 0);

    // R3 / R7 directed buckets
    measure("R3 p147", 0, 74, 73, 1);
    measure("R3 p320", 0, 160, 160, 1);
    measure("R3 p588", 0, 300, 288, 1);
    measure("R3 p640", 0, 320, 320, 1);
    measure("R3 p882", 0, 441, 441, 1);
    measure("R7 p1010", 0, 505, 505, 1);

    // R8: select B, A changes do not matter
    hi_a = 100; lo_a = 100;
    measure("R8 b300", 1, 150, 150, 1);
    hi_a = 37; lo_a = 37;
    repeat (800) @(negedge clk);
    cmd(1, 2'b00);
    chk("R8 a ignored", cnt_now(), 300);
    // R2: bit1 has priority
    hi_b = 200; lo_b = 200;
    cmd(0, 2'b11);
    repeat (1300) @(negedge clk);
    cmd(1, 2'b00);
    chk("R2 priority b", cnt_now(), 400);

    // R4: save ignores src bits, count held
    measure("R4 a600", 0, 300, 300, 1);
    cmd(1, 2'b10);
    chk("R4 src ignored", cnt_now(), 600);
    repeat (300) @(negedge clk);
    chk("R4 held", cnt_now(), 600);
    cmd(1, 2'b00);
    chk("R4 still a", cnt_now(), 600);

    // R5 gating
    data_ok_a = 0;
    cmd(1, 2'b00);
    chk("R5 data low", cnt_now(), 0);
    chk("R5 rate zero", int'(rate_hz), 0);
    data_ok_a = 1; clk_ok_a = 0;
    cmd(1, 2'b00);
    chk("R5 clk low", cnt_now(), 0);
    clk_ok_a = 1; clk_ok_b = 0; data_ok_b = 0;
    cmd(1, 2'b00);
    chk("R5 other flags", cnt_now(), 600);
    clk_ok_b = 1; data_ok_b = 1;

    // R6 saturation boundaries and stickiness
    measure("R6 p1023", 0, 512, 511, 1);
    measure("R6 p1024", 0, 512, 512, 1);
    measure("R6 p1500", 0, 750, 750, 1);
    hi_a = 250; lo_a = 250;
    repeat (3200) @(negedge clk);
    cmd(1, 2'b00);
    chk("R6 recount", cnt_now(), 500);
    chk("R6 sticky", int'(overflow), 1);
    cmd(0, 2'b01);
    chk("R2 start clears ovf", int'(overflow), 0);

    // random mix
    for (int i = 0; i < 10; i++) begin
      bit ub;
      int h, l;
      bit ok;
      ub = 1'($urandom % 2);
      h = 60 + int'($urandom % 500);
      l = 60 + int'($urandom % 500);
      ok = ($urandom % 4) != 0;
      if (ub) begin clk_ok_b = ok; clk_ok_a = 1; end
      else begin clk_ok_a = ok; clk_ok_b = 1; end
      measure("R3 random", ub, h, l, ok);
    end
    clk_ok_a = 1; clk_ok_b = 1;
    done = 1;
  end

  initial begin
    void'($urandom(32'h1234));
    fork
      begin wait (done); end
      begin
        repeat (190000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule